// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block gathers interrupt requests from a parameterised set of sources and turns them into one general request line for a processor. There are five external and eight internal sources by default. Each request is caught in a sticky flag. A per-source allow bit decides whether that flag may contribute to the general request. A single global enable gates the line as a whole. A small register port lets software read the flags, clear chosen flags and program the allow bits and the global enable.

Reading the flag register hands software the pending set and clears those flags in the same access. Software therefore never has to write back what it has just serviced. When the processor enters its halt state, the global enable switches itself on, so that any pending or later request can wake it.

External inputs are levels that may stay asserted for a long time. By default they are edge-qualified: only a rising edge raises a flag. A parameter selects plain level capture instead. Internal inputs are one-cycle pulses.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every flag, every allow bit, the global enable, `irq_o` and `rdata_o` are zero.
- R2: Flag vector bit positions: external source k is bit k (0 to 4), and internal source j is bit 5+j (5 to 12). An internal request pulse in cycle t makes its flag read as 1 in any flag read issued from cycle t+1 on.
- R3: With edge qualification on, an external flag is set only in the cycle after its input goes from 0 to 1. An input held at 1 does not set the flag again after the flag has been cleared.
- R4: A source whose allow bit is 0 still sets its flag, and that flag does not assert `irq_o`. Once the allow bit is 1, the same flag does assert `irq_o`.
- R5: `irq_o` equals the global enable ANDed with the OR over all sources of (flag AND allow bit). It is a combinational function of registered state, so it changes in the cycle after the event that changes that state.
- R6: A read of address 0 issued in cycle t returns, in `rdata_o` from cycle t+1, the flag vector as it stood in cycle t. Every flag it returned as 1 is cleared at that same edge. `rdata_o` holds its value until the next read.
- R7: A write to address 2 clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R8: A request arriving in the same cycle as a read-clear or a write-clear of its flag wins, and the flag stays set.
- R9: The global enable is bit 0 of address 3 and can be written and read back. A 0-to-1 transition of `halt_i` sets the global enable, and this overrides a write of 0 to address 3 in the same cycle. A halt held high does not set the enable again.
- R10: Address 1 holds the allow bits in the flag bit positions. It reads back as written, masked to the number of sources. Address 2 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_req_i | input | N_EXT | External request inputs (levels) |
| int_req_i | input | N_INT | Internal request pulses |
| halt_i | input | 1 | High while the processor is halted |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 flags, 1 allow, 2 clear, 3 control |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | General interrupt request |

## Verification
Every state change lands at the edge that samples its cause. `irq_o` therefore reflects a request, an allow change or a global-enable change one cycle after the stimulus. `rdata_o` carries a read result one cycle after the read strobe. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares both outputs at the following falling edge, which is exactly the first point where the due value is present. The directed cases that race a request against a clear, or a halt entry against a control write, read the state back through the register port in the next access and check it there.

// File: rtl/irq_pkg.sv
package irq_pkg;

   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_FLAGS = 2'd0,
      REG_ALLOW = 2'd1,
      REG_CLEAR = 2'd2,
      REG_CTRL  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
   parameter int unsigned WIDTH    = 5,
   parameter bit          EDGE_DET = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] req_i,
   output logic [WIDTH-1:0] set_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("irq_src_cond: WIDTH must be at least 1");
      end

      if (EDGE_DET) begin : g_edge
         logic [WIDTH-1:0] prev_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) prev_q <= '0;
            else         prev_q <= req_i;
         end
         assign set_o = req_i & ~prev_q;
      end else begin : g_level
         assign set_o = req_i;
      end
   endgenerate

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned N_SRC = 13
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] flags_o
);

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)       flag_q <= 1'b0;
            else if (set_i[i]) flag_q <= 1'b1;
            else if (clr_i[i]) flag_q <= 1'b0;
         end
         assign flags_o[i] = flag_q;
      end
   endgenerate

endmodule

// File: rtl/irq_regs.sv
module irq_regs
   import irq_pkg::*;
#(
   parameter int unsigned N_SRC  = 13,
   parameter int unsigned DATA_W = 16
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  halt_i,
   input  logic                  rd_en_i,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   input  logic [N_SRC-1:0]      flags_i,
   output logic [N_SRC-1:0]      clr_o,
   output logic [N_SRC-1:0]      allow_o,
   output logic                  gie_o,
   output logic [DATA_W-1:0]     rdata_o
);

   localparam int unsigned PAD_W = DATA_W - N_SRC;

   reg_sel_e          sel;
   logic [N_SRC-1:0]  allow_q;
   logic              gie_q;
   logic              halt_q;
   logic              halt_rise;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] rd_mux;

   assign sel       = reg_sel_e'(addr_i);
   assign halt_rise = halt_i & ~halt_q;

   always_comb begin
      clr_o = '0;
      if (rd_en_i && sel == REG_FLAGS) clr_o = clr_o | flags_i;
      if (wr_en_i && sel == REG_CLEAR) clr_o = clr_o | wdata_i[N_SRC-1:0];
   end

   generate
      if (PAD_W > 0) begin : g_pad
         always_comb begin
            unique case (sel)
               REG_FLAGS: rd_mux = {{PAD_W{1'b0}}, flags_i};
               REG_ALLOW: rd_mux = {{PAD_W{1'b0}}, allow_q};
               REG_CLEAR: rd_mux = '0;
               REG_CTRL:  rd_mux = {{(DATA_W-1){1'b0}}, gie_q};
               default:   rd_mux = '0;
            endcase
         end
      end else begin : g_nopad
         always_comb begin
            unique case (sel)
               REG_FLAGS: rd_mux = flags_i;
               REG_ALLOW: rd_mux = allow_q;
               REG_CLEAR: rd_mux = '0;
               REG_CTRL:  rd_mux = {{(DATA_W-1){1'b0}}, gie_q};
               default:   rd_mux = '0;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         allow_q <= '0;
         gie_q   <= 1'b0;
         halt_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         halt_q <= halt_i;
         if (wr_en_i && sel == REG_ALLOW) allow_q <= wdata_i[N_SRC-1:0];
         if (halt_rise)                       gie_q <= 1'b1;
         else if (wr_en_i && sel == REG_CTRL) gie_q <= wdata_i[0];
         if (rd_en_i) rdata_q <= rd_mux;
      end
   end

   assign allow_o = allow_q;
   assign gie_o   = gie_q;
   assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned N_EXT    = 5,
   parameter int unsigned N_INT    = 8,
   parameter int unsigned DATA_W   = 16,
   parameter bit          EXT_EDGE = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [N_EXT-1:0]      ext_req_i,
   input  logic [N_INT-1:0]      int_req_i,
   input  logic                  halt_i,
   input  logic                  rd_en_i,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rdata_o,
   output logic                  irq_o
);

   localparam int unsigned N_SRC = N_EXT + N_INT;

   generate
      if (N_EXT < 1 || N_INT < 1) begin : g_bad_cnt
         $error("irq_flag_ctrl: each source group needs at least one source");
      end
      if (N_SRC > DATA_W) begin : g_bad_dw
         $error("irq_flag_ctrl: DATA_W must hold all source flags");
      end
   endgenerate

   logic [N_EXT-1:0] ext_set;
   logic [N_SRC-1:0] set_vec;
   logic [N_SRC-1:0] clr_vec;
   logic [N_SRC-1:0] flags;
   logic [N_SRC-1:0] allow;
   logic             gie;

   irq_src_cond #(
      .WIDTH    (N_EXT),
      .EDGE_DET (EXT_EDGE)
   ) u_ext_cond (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (ext_req_i),
      .set_o  (ext_set)
   );

   assign set_vec = {int_req_i, ext_set};

   irq_flag_bank #(
      .N_SRC (N_SRC)
   ) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_vec),
      .clr_i   (clr_vec),
      .flags_o (flags)
   );

   irq_regs #(
      .N_SRC  (N_SRC),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .halt_i  (halt_i),
      .rd_en_i (rd_en_i),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .flags_i (flags),
      .clr_o   (clr_vec),
      .allow_o (allow),
      .gie_o   (gie),
      .rdata_o (rdata_o)
   );

   assign irq_o = gie & (|(flags & allow));

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
   parameter int unsigned N_SRC  = 13,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              halt_i,
   input logic              rd_en_i,
   input logic [1:0]        addr_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              irq_o,
   input logic [N_SRC-1:0]  flags,
   input logic [N_SRC-1:0]  allow,
   input logic [N_SRC-1:0]  set_vec,
   input logic              gie
);

   // R5: no request while the global enable is off
   a_r5_irq_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gie |-> !irq_o);

   // R4: a request needs at least one flag that is allowed
   a_r4_irq_needs_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ((flags & allow) != '0));

   // R9: halt entry turns the global enable on
   a_r9_halt_sets_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(halt_i) |=> gie);

   // R8: a new request always leaves its flag set
   a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

   // R6: flag read returns the flags of the read cycle
   a_r6_read_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == 2'd0) |=> (rdata_o == DATA_W'($past(flags))));

   // R6: flags returned by a read are gone unless requested again
   a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == 2'd0) |=> ((flags & $past(flags) & ~$past(set_vec)) == '0));

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
   .N_SRC  (N_SRC),
   .DATA_W (DATA_W)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .halt_i  (halt_i),
   .rd_en_i (rd_en_i),
   .addr_i  (addr_i),
   .rdata_o (rdata_o),
   .irq_o   (irq_o),
   .flags   (flags),
   .allow   (allow),
   .set_vec (set_vec),
   .gie     (gie)
);

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;

   localparam int N_EXT = 5;
   localparam int N_INT = 8;
   localparam int N_SRC = N_EXT + N_INT;
   localparam int DW    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N_EXT-1:0] ext = '0;
   logic [N_INT-1:0] intr = '0;
   logic halt = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [N_SRC-1:0] m_flags = '0, m_allow = '0;
   logic [N_EXT-1:0] m_ext_prev = '0;
   logic m_gie = 1'b0, m_halt_prev = 1'b0;
   logic [DW-1:0] m_rdata = '0;

   irq_flag_ctrl i_irq_flag_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .ext_req_i(ext), .int_req_i(intr),
      .halt_i(halt), .rd_en_i(rd), .wr_en_i(wr), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   always #2 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_irq();
      return m_gie & (|(m_flags & m_allow));
   endfunction

   // one clock: model advances from driven inputs, outputs checked at next falling edge
   task automatic step();
      logic [N_SRC-1:0] setv, clrv, nflags, nallow;
      logic ngie;
      logic [DW-1:0] nrd;
      bit was_rd;
      logic [1:0] a;
      setv = {intr, ext & ~m_ext_prev};
      clrv = '0;
      if (rd && addr == 2'd0) clrv |= m_flags;
      if (wr && addr == 2'd2) clrv |= wdata[N_SRC-1:0];
      nflags = (m_flags & ~clrv) | setv;
      nallow = (wr && addr == 2'd1) ? wdata[N_SRC-1:0] : m_allow;
      ngie = (halt && !m_halt_prev) ? 1'b1 : ((wr && addr == 2'd3) ? wdata[0] : m_gie);
      nrd = m_rdata;
      if (rd) case (addr)
         2'd0: nrd = DW'(m_flags);
         2'd1: nrd = DW'(m_allow);
         2'd2: nrd = '0;
         default: nrd = DW'(m_gie);
      endcase
      was_rd = rd; a = addr;
      @(posedge clk);
      @(negedge clk);
      m_flags = nflags; m_allow = nallow; m_gie = ngie; m_rdata = nrd;
      m_ext_prev = ext; m_halt_prev = halt;
      chk("R5 irq", irq, exp_irq());
      if (was_rd) chk(a == 2'd0 ? "R6 rdata" : "R10 rdata", rdata, m_rdata);
      rd = 1'b0; wr = 1'b0; intr = '0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [DW-1:0] v);
      rd = 1'b1; addr = a; step(); v = rdata;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
      wr = 1'b1; addr = a; wdata = d; step();
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      chk("R1 rdata", rdata, 0);
      chk("R1 irq", irq, 0);
      rst_n = 1'b1;
      rd_reg(2'd0, v); chk("R1 flags", v, 0);
      rd_reg(2'd1, v); chk("R1 allow", v, 0);
      rd_reg(2'd3, v); chk("R1 gie", v, 0);

      // R2 internal pulse, bit 5+j
      intr = 8'h01; step();
      rd_reg(2'd0, v); chk("R2 int0 -> bit5", v, 16'h0020);
      rd_reg(2'd0, v); chk("R6 read cleared", v, 0);

      // R3 external edge qualification
      ext = 5'b00010; step();
      rd_reg(2'd0, v); chk("R3 edge sets bit1", v, 16'h0002);
      step(); step();
      rd_reg(2'd0, v); chk("R3 held level no reset", v, 0);
      ext = '0; step();
      ext = 5'b00010; step();
      rd_reg(2'd0, v); chk("R3 second edge", v, 16'h0002);
      ext = '0; step();

      // R4 masked source still flags, does not request
      wr_reg(2'd3, 16'h0001);
      intr = 8'h80; step();
      chk("R4 masked no irq", irq, 0);
      wr_reg(2'd1, 16'h1000);
      chk("R4 allowed irq", irq, 1);
      rd_reg(2'd1, v); chk("R10 allow readback", v, 16'h1000);
      wr_reg(2'd1, 16'hFFFF);
      rd_reg(2'd1, v); chk("R10 allow width", v, 16'h1FFF);

      // R7 selective clear
      intr = 8'h03; step();
      wr_reg(2'd2, 16'h1000);
      chk("R5 irq after clear", irq, 1);
      rd_reg(2'd0, v); chk("R7 others kept", v, 16'h0060);
      rd_reg(2'd2, v); chk("R10 clear reads zero", v, 0);

      // R8 request races read-clear and write-clear
      intr = 8'h04; rd = 1'b1; addr = 2'd0; step();
      chk("R8 read saw old", rdata, 0);
      rd_reg(2'd0, v); chk("R8 set beats read-clear", v, 16'h0080);
      intr = 8'h04; step();
      intr = 8'h04; wr = 1'b1; addr = 2'd2; wdata = 16'h0080; step();
      rd_reg(2'd0, v); chk("R8 set beats write-clear", v, 16'h0080);

      // R9 halt entry beats write of 0
      wr_reg(2'd3, 16'h0000);
      rd_reg(2'd3, v); chk("R9 gie written 0", v, 0);
      halt = 1'b1; wr = 1'b1; addr = 2'd3; wdata = 16'h0000; step();
      rd_reg(2'd3, v); chk("R9 halt sets gie", v, 1);
      wr_reg(2'd3, 16'h0000);
      rd_reg(2'd3, v); chk("R9 held halt no re-set", v, 0);
      halt = 1'b0; step();

      // random phase
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         rd = (r < 25);
         wr = (r >= 25 && r < 45);
         addr = 2'($urandom_range(0, 3));
         wdata = 16'($urandom);
         if ($urandom_range(0, 3) == 0) intr = 8'(1 << $urandom_range(0, 7));
         if ($urandom_range(0, 5) == 0) ext = 5'($urandom);
         if ($urandom_range(0, 15) == 0) halt = ~halt;
         step();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule